// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

The block gathers sixteen level interrupt lines from board peripherals into one active-high level request to a host processor. Each line is brought into the block clock domain through a two-stage synchroniser. A latched pending word records every line that has been high. An enable word selects which pending lines may raise the host request. The host reaches the block over a small synchronous register bus that carries a byte offset, a write strobe, a read strobe, 16-bit write data and registered 16-bit read data.

The enable word has no plain write path. Software turns lines on by writing ones to one offset and turns them off by writing ones to another offset, so a single write never disturbs lines it does not name. Pending bits are cleared by writing ones to them. A line that is still high sets its pending bit again on the next clock, which gives level behaviour. Two of the lines, 10 and 11, are normally wired to the two channels of an external dual UART. They are handled like every other line.

Top module: `irqagg_top`

## Requirements
- R1: Reading offset 0x18 returns the synchronised input lines, bit i for line i, whatever the enable word holds. A change on a line shows up in this word two clocks after it is applied.
- R2: A pending bit sets on the clock after its synchronised line is high, even when the line is disabled. It then holds at 1 until software clears it. Reading offset 0x16 returns the pending word.
- R3: Writing to offset 0x1A sets the enable bit of every line whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R4: Writing to offset 0x1C clears the enable bit of every line whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R5: Reading offset 0x1A returns the current enable word. Reading offset 0x1C returns 0.
- R6: Writing to offset 0x16 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R7: When a clear of a pending bit lands in the same cycle as a high synchronised line for that bit, the bit stays at 1.
- R8: The output irq_o is high exactly while some bit is 1 in both the pending word and the enable word.
- R9: After reset the enable word and the pending word are all zero, and irq_o is low.
- R10: A read of any offset other than 0x16, 0x18, 0x1A or 0x1C returns 0. A write to offset 0x18, or to any such other offset, changes neither the pending word nor the enable word.
- R11: Read data appears on rd_data_o in the clock after the read strobe. In any clock that follows a clock without a read strobe, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | 16 | Peripheral interrupt lines, asynchronous, active high |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe, one clock per write |
| rd_i | input | 1 | Read strobe, one clock per read |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level request to the host, active high |

## Verification
The hardest case to reach is a clear of a pending bit that lands in the very clock in which the same line is still high after synchronisation. Only then does the rule that the set wins decide the result. The bench holds lines high across writes of ones to the pending offset. It also runs a long random phase in which lines toggle rarely and writes of random masks hit every offset. A bench model checks the read data and irq_o on every clock, so the set-wins rule and the checks of enable bits that must stay unchanged are covered many times. Directed steps before the random phase also cover writes to the current-input offset and to unmapped offsets, which must change nothing.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_PEND = 8'h16;
  localparam logic [OFS_W-1:0] OFS_RAW  = 8'h18;
  localparam logic [OFS_W-1:0] OFS_ESET = 8'h1A;
  localparam logic [OFS_W-1:0] OFS_ECLR = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_RAW,
    SEL_ESET,
    SEL_ECLR
  } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_regif.sv
module irqagg_regif
  import irqagg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [N-1:0]     wr_data_i,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     raw_i,
  input  logic [N-1:0]     en_i,
  output logic [N-1:0]     pend_clr_o,
  output logic [N-1:0]     en_set_o,
  output logic [N-1:0]     en_clr_o,
  output logic [N-1:0]     rd_data_o
);
  reg_sel_e     sel;
  logic [N-1:0] rd_mux;
  logic [N-1:0] rd_d;
  logic [N-1:0] rd_q;

  always_comb begin
    unique case (addr_i)
      OFS_PEND: sel = SEL_PEND;
      OFS_RAW:  sel = SEL_RAW;
      OFS_ESET: sel = SEL_ESET;
      OFS_ECLR: sel = SEL_ECLR;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    pend_clr_o = (wr_i && sel == SEL_PEND) ? wr_data_i : '0;
    en_set_o   = (wr_i && sel == SEL_ESET) ? wr_data_i : '0;
    en_clr_o   = (wr_i && sel == SEL_ECLR) ? wr_data_i : '0;
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_mux = pend_i;
      SEL_RAW:  rd_mux = raw_i;
      SEL_ESET: rd_mux = en_i;
      default:  rd_mux = '0;
    endcase
    rd_d = rd_i ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R10: unmapped offsets read as zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel == SEL_NONE) |=> (rd_data_o == '0));

  // R11: idle clocks leave read data at zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rd_data_o == '0));
endmodule

// File: rtl/irqagg_core.sv
module irqagg_core #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] pend_clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] pend_d, pend_q;
  logic [N-1:0] en_d, en_q;
  logic         pend_ce, en_ce;

  always_comb begin
    pend_ce = (|raw_i) || (|pend_clr_i);
    pend_d  = (pend_q & ~pend_clr_i) | raw_i;
    en_ce   = (|en_set_i) || (|en_clr_i);
    en_d    = (en_q | en_set_i) & ~en_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  // R3: ones written to the set offset are enabled afterwards
  a_r3_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));

  // R4: ones written to the clear offset are disabled afterwards
  a_r4_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en_q & $past(en_clr_i)) == '0));

  // R7: a high synchronised line always leaves its pending bit set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(raw_i)) == $past(raw_i)));

  // R2: pending bits only drop when software clears them
  a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(pend_clr_i) & ~pend_q) == '0));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned N_LINES     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [OFS_W-1:0]   addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic [N_LINES-1:0] rd_data_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] en;
  logic [N_LINES-1:0] pend_clr;
  logic [N_LINES-1:0] en_set;
  logic [N_LINES-1:0] en_clr;

  irqagg_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lines_i),
    .q_o   (raw)
  );

  irqagg_regif #(.N(N_LINES)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wr_data_i  (wr_data_i),
    .pend_i     (pend),
    .raw_i      (raw),
    .en_i       (en),
    .pend_clr_o (pend_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .rd_data_o  (rd_data_o)
  );

  irqagg_core #(.N(N_LINES)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (raw),
    .pend_clr_i (pend_clr),
    .en_set_i   (en_set),
    .en_clr_i   (en_clr),
    .pend_o     (pend),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  // R8: no request is possible while nothing is enabled
  a_r8_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);
endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] lines;
  logic [7:0]  addr;
  logic        wr, rd;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int          total, bad;
  bit          done;

  irqagg_top u_irqagg_top (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model written from the requirements
  logic [15:0] m_s1, m_s2, m_pend, m_en, m_rd;

  function automatic logic [15:0] rd_expect(logic [7:0] a, logic [15:0] p,
                                            logic [15:0] r, logic [15:0] e);
    case (a)
      8'h16:   return p;
      8'h18:   return r;
      8'h1A:   return e;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_en <= '0; m_rd <= '0;
    end else begin
      m_s1   <= lines;
      m_s2   <= m_s1;
      m_pend <= (m_pend & ~((wr && addr == 8'h16) ? wdata : 16'h0)) | m_s2;
      if (wr && addr == 8'h1A) m_en <= m_en | wdata;
      if (wr && addr == 8'h1C) m_en <= m_en & ~wdata;
      m_rd   <= rd ? rd_expect(addr, m_pend, m_s2, m_en) : 16'h0;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    total = 0; bad = 0; done = 0;
    lines = '0; addr = '0; wr = 0; rd = 0; wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    chk("R9 irq after reset", {15'h0, irq}, 16'h0);
    rd_reg(8'h16, v); chk("R9 pending after reset", v, 16'h0);
    rd_reg(8'h1A, v); chk("R9 enable after reset", v, 16'h0);

    lines = 16'h0C00;
    idle(4);
    rd_reg(8'h18, v); chk("R1 raw lines 10 and 11", v, 16'h0C00);
    rd_reg(8'h16, v); chk("R2 pending latches while disabled", v, 16'h0C00);
    chk("R8 no irq while disabled", {15'h0, irq}, 16'h0);

    wr_reg(8'h1A, 16'h0400);
    rd_reg(8'h1A, v); chk("R3 R5 enable readback", v, 16'h0400);
    chk("R8 irq with enabled pending", {15'h0, irq}, 16'h1);
    wr_reg(8'h1A, 16'h8001);
    wr_reg(8'h1C, 16'h0401);
    rd_reg(8'h1A, v); chk("R4 clear leaves others", v, 16'h8000);
    chk("R8 irq drops after disable", {15'h0, irq}, 16'h0);
    rd_reg(8'h1C, v); chk("R5 clear offset reads zero", v, 16'h0);

    wr_reg(8'h16, 16'h0C00);
    rd_reg(8'h16, v); chk("R7 clear while line high", v, 16'h0C00);

    lines = 16'h0;
    idle(4);
    wr_reg(8'h16, 16'h0400);
    rd_reg(8'h16, v); chk("R6 one bit cleared", v, 16'h0800);
    wr_reg(8'h16, 16'h0000);
    rd_reg(8'h16, v); chk("R6 zero write no effect", v, 16'h0800);
    rd_reg(8'h18, v); chk("R1 raw low again", v, 16'h0);

    wr_reg(8'h18, 16'hFFFF);
    wr_reg(8'h20, 16'hFFFF);
    rd_reg(8'h1A, v); chk("R10 enable untouched", v, 16'h8000);
    rd_reg(8'h16, v); chk("R10 pending untouched", v, 16'h0800);
    rd_reg(8'h20, v); chk("R10 unmapped read", v, 16'h0);
    idle(1);
    chk("R11 idle read data zero", rdata, 16'h0);

    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R11 R1 R2 random read data", rdata, m_rd);
      chk("R8 random irq", {15'h0, irq}, {15'h0, |(m_pend & m_en)});
      for (int b = 0; b < 16; b++)
        if ($urandom_range(0, 19) == 0) lines[b] = ~lines[b];
      case ($urandom_range(0, 5))
        0: addr = 8'h16;
        1: addr = 8'h18;
        2: addr = 8'h1A;
        3: addr = 8'h1C;
        4: addr = 8'h1A;
        default: addr = 8'($urandom_range(0, 255));
      endcase
      wdata = 16'($urandom());
      wr = ($urandom_range(0, 3) == 0);
      rd = !wr && ($urandom_range(0, 1) == 0);
    end
    @(negedge clk);
    wr = 0; rd = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule